// File: doc/BRIEF.md
# Fractional-Rate VGA Pixel Streamer

This block produces a complete VGA raster from a fast system clock. The pixel rate is set by a numerically controlled oscillator, not by a clock divider, so any pixel rate up to one pixel per system clock can be chosen. For example, 25 MHz pixels can be taken from an 80 MHz clock. Each pixel step moves a horizontal and a vertical position counter. During visible positions the block fetches one 16-bit RGB565 word from a frame buffer through a simple read port. The fetch address wraps back to zero after a full frame of pixels.

Each fetched word is split into red, green and blue fields. Each field is widened to 8 bits and multiplied by a common gain. The result drives three 8-bit DAC codes. Two sync outputs are also driven, and each has its own polarity select. The default geometry is a 640-pixel line and a 350-line visible window, with uneven blanking above and below it. Every width and height is a parameter, so the same logic can be run in a small raster.

Top module: `vga_frac_streamer`

## Requirements
- R1: A pixel step occurs on every carry out of a 32-bit phase accumulator that starts at zero on reset and adds twice the frequency word each clock. After e clocks the block has taken floor(e·2F/2^32) steps. A word above 2^31 acts as 2^31, which gives one step per clock. A word of zero gives no step.
- R2: Each line runs, in pixel steps: 16 front-porch, 96 horizontal sync, 48 back-porch, then 640 visible.
- R3: hsync is active-low when hsync_pol is 0 and active-high when hsync_pol is 1. vsync follows vsync_pol in the same way.
- R4: Each field runs 90 blank lines, 350 visible lines, 83 blank lines, then 2 lines with vsync active for every position of those lines.
- R5: rd_req is a one-clock pulse, issued only when the step enters a visible pixel. rd_addr is a byte address: 0 for the first visible pixel, rising by 2 per visible pixel, and back to 0 after 640·350·2 bytes. rd_data is taken one clock after the pulse.
- R6: The DAC codes are 0 for every non-visible position, including sync.
- R7: The word is read as red in bits 15:11, green in bits 10:5 and blue in bits 4:0. The 5-bit fields become {f, f[4:2]} and the 6-bit field becomes {f, f[5:4]}.
- R8: Each widened channel c is output as (c·k)>>7, where k is intensity. Any intensity above 128 acts as 128, which is unity gain.
- R9: After reset the DAC codes are 0, both syncs are inactive and rd_req is 0. The first step enters the first front-porch position of the first top blank line. The outputs for a pixel appear two clocks after the step that entered it and hold until the next pixel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_word | input | 32 | Pixel rate, (fpix/fclk)·2^31 |
| intensity | input | 8 | Channel gain, 128 = unity |
| hsync_pol | input | 1 | 0: hsync active-low, 1: active-high |
| vsync_pol | input | 1 | 0: vsync active-low, 1: active-high |
| rd_req | output | 1 | One-clock frame-buffer read strobe |
| rd_addr | output | 19 | Byte address of the requested word |
| rd_data | input | 16 | RGB565 word, valid the clock after rd_req |
| dac_r | output | 8 | Red DAC code |
| dac_g | output | 8 | Green DAC code |
| dac_b | output | 8 | Blue DAC code |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |

## Verification
The bench shrinks the raster to an 11-by-9 position field. It then compares every output on every clock against an arithmetic model of the step count. The frequency words tried are:
- full rate, which shows the pipeline at one step per clock;
- the 25/80 ratio, which shows uneven step spacing;
- an above-range word, which exercises the clamp;
- zero, which freezes the raster in its reset state;
- a one-third ratio across two field wraps, which exercises address wrap.

The gain takes unity, half, above-range and odd values, and both sync polarities are used. A data pattern that differs at every address separates wrong addresses from wrong colour arithmetic.

// File: rtl/vga_frac_pkg.sv
package vga_frac_pkg;

  typedef struct packed {
    logic vis;
    logic hs;
    logic vs;
  } px_attr_t;

  localparam logic [7:0] GAIN_UNITY = 8'd128;

  function automatic logic [7:0] widen5(input logic [4:0] f);
    return {f, f[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] f);
    return {f, f[5:4]};
  endfunction

  function automatic logic [7:0] gain_apply(input logic [7:0] c, input logic [7:0] k);
    logic [7:0]  kk;
    logic [15:0] prod;
    kk   = (k > GAIN_UNITY) ? GAIN_UNITY : k;
    prod = {8'd0, c} * {8'd0, kk};
    return prod[14:7];
  endfunction

endpackage

// File: rtl/vga_nco.sv
module vga_nco #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] freq_word,
  output logic               tick
);
  localparam logic [PHASE_W-1:0] HALF = {1'b1, {(PHASE_W-1){1'b0}}};

  logic [PHASE_W-1:0] acc;
  logic [PHASE_W-1:0] eff;
  logic [PHASE_W:0]   sum;

  always_comb begin
    eff  = (freq_word > HALF) ? HALF : freq_word;
    sum  = {1'b0, acc} + {eff, 1'b0};
    tick = sum[PHASE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= sum[PHASE_W-1:0];
  end

  // R1: full-rate or clamped word steps every clock
  p_full_rate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_word >= HALF) |-> tick);
  // R1: zero word never steps
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_word == '0) |-> !tick);

endmodule

// File: rtl/vga_raster.sv
module vga_raster import vga_frac_pkg::*; #(
  parameter int HFP    = 16,
  parameter int HSW    = 96,
  parameter int HBP    = 48,
  parameter int HACT   = 640,
  parameter int VTOP   = 90,
  parameter int VACT   = 350,
  parameter int VBOT   = 83,
  parameter int VSW    = 2,
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  output px_attr_t          attr_q,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int HTOT = HFP + HSW + HBP + HACT;
  localparam int VTOT = VTOP + VACT + VBOT + VSW;
  localparam int HW   = $clog2(HTOT);
  localparam int VW   = $clog2(VTOT);
  localparam logic [HW-1:0] H_LAST  = HW'(HTOT - 1);
  localparam logic [HW-1:0] H_SYNC0 = HW'(HFP);
  localparam logic [HW-1:0] H_SYNC1 = HW'(HFP + HSW);
  localparam logic [HW-1:0] H_VIS0  = HW'(HFP + HSW + HBP);
  localparam logic [VW-1:0] V_LAST  = VW'(VTOT - 1);
  localparam logic [VW-1:0] V_VIS0  = VW'(VTOP);
  localparam logic [VW-1:0] V_VIS1  = VW'(VTOP + VACT);
  localparam logic [VW-1:0] V_SYNC0 = VW'(VTOT - VSW);
  localparam logic [ADDR_W-1:0] FB_LAST = ADDR_W'(HACT * VACT * 2 - 2);

  logic [HW-1:0]     h, h_nx;
  logic [VW-1:0]     v, v_nx;
  logic [ADDR_W-1:0] ptr, ptr_nx;
  logic              line_end;
  px_attr_t          attr_nx;

  always_comb begin
    line_end    = (h == H_LAST);
    h_nx        = line_end ? '0 : h + 1'b1;
    v_nx        = !line_end ? v : ((v == V_LAST) ? '0 : v + 1'b1);
    attr_nx.vis = (h_nx >= H_VIS0) && (v_nx >= V_VIS0) && (v_nx < V_VIS1);
    attr_nx.hs  = (h_nx >= H_SYNC0) && (h_nx < H_SYNC1);
    attr_nx.vs  = (v_nx >= V_SYNC0);
    ptr_nx      = (ptr == FB_LAST) ? '0 : ptr + ADDR_W'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h       <= H_LAST;
      v       <= V_LAST;
      attr_q  <= '0;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      ptr     <= '0;
    end else begin
      rd_req <= 1'b0;
      if (tick) begin
        h      <= h_nx;
        v      <= v_nx;
        attr_q <= attr_nx;
        if (attr_nx.vis) begin
          rd_req  <= 1'b1;
          rd_addr <= ptr;
          ptr     <= ptr_nx;
        end
      end
    end
  end

  // R5: a fetch is only ever requested for a visible position
  p_req_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> attr_q.vis);
  // R5: fetch pointer stays inside the frame buffer
  p_ptr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr <= FB_LAST) && !ptr[0]);
  // R4: vertical sync only changes at a line boundary
  p_vs_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !line_end) |=> $stable(attr_q.vs));
  // R2: horizontal and vertical sync never overlap the visible window
  p_sync_vs_vis_r2: assert property (@(posedge clk) disable iff (!rst_n)
    attr_q.vis |-> !(attr_q.hs || attr_q.vs));

endmodule

// File: rtl/vga_pixout.sv
module vga_pixout import vga_frac_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  px_attr_t    attr_i,
  input  logic [15:0] px_word,
  input  logic [7:0]  gain,
  input  logic        hpol,
  input  logic        vpol,
  output logic [7:0]  dac_r,
  output logic [7:0]  dac_g,
  output logic [7:0]  dac_b,
  output logic        hsync,
  output logic        vsync
);
  logic       t1, t2;
  px_attr_t   s2;
  logic       hs_act, vs_act;
  logic [7:0] r8, g8, b8;

  always_comb begin
    r8 = gain_apply(widen5(px_word[15:11]), gain);
    g8 = gain_apply(widen6(px_word[10:5]),  gain);
    b8 = gain_apply(widen5(px_word[4:0]),   gain);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1     <= 1'b0;
      t2     <= 1'b0;
      s2     <= '0;
      hs_act <= 1'b0;
      vs_act <= 1'b0;
      dac_r  <= '0;
      dac_g  <= '0;
      dac_b  <= '0;
    end else begin
      t1 <= tick;
      t2 <= t1;
      if (t1) s2 <= attr_i;
      if (t2) begin
        hs_act <= s2.hs;
        vs_act <= s2.vs;
        dac_r  <= s2.vis ? r8 : 8'd0;
        dac_g  <= s2.vis ? g8 : 8'd0;
        dac_b  <= s2.vis ? b8 : 8'd0;
      end
    end
  end

  assign hsync = ~(hs_act ^ hpol);
  assign vsync = ~(vs_act ^ vpol);

  // R6: any active sync level comes with black
  p_sync_black_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((hsync == hpol) || (vsync == vpol)) |-> (dac_r == 8'd0 && dac_g == 8'd0 && dac_b == 8'd0));
  // R6: a blank position loads black
  p_blank_black_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (t2 && !s2.vis) |=> (dac_r == 8'd0 && dac_g == 8'd0 && dac_b == 8'd0));
  // R9: outputs hold between pixel loads
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !t2 |=> ($stable(dac_r) && $stable(dac_g) && $stable(dac_b)));

endmodule

// File: rtl/vga_frac_streamer.sv
module vga_frac_streamer import vga_frac_pkg::*; #(
  parameter int HFP     = 16,
  parameter int HSW     = 96,
  parameter int HBP     = 48,
  parameter int HACT    = 640,
  parameter int VTOP    = 90,
  parameter int VACT    = 350,
  parameter int VBOT    = 83,
  parameter int VSW     = 2,
  parameter int PHASE_W = 32,
  localparam int ADDR_W = $clog2(HACT * VACT * 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASE_W-1:0] freq_word,
  input  logic [7:0]        intensity,
  input  logic              hsync_pol,
  input  logic              vsync_pol,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [15:0]       rd_data,
  output logic [7:0]        dac_r,
  output logic [7:0]        dac_g,
  output logic [7:0]        dac_b,
  output logic              hsync,
  output logic              vsync
);
  logic     px_tick;
  px_attr_t px_attr;

  vga_nco #(.PHASE_W(PHASE_W)) u_nco (
    .clk       (clk),
    .rst_n     (rst_n),
    .freq_word (freq_word),
    .tick      (px_tick)
  );

  vga_raster #(
    .HFP(HFP), .HSW(HSW), .HBP(HBP), .HACT(HACT),
    .VTOP(VTOP), .VACT(VACT), .VBOT(VBOT), .VSW(VSW),
    .ADDR_W(ADDR_W)
  ) u_raster (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (px_tick),
    .attr_q  (px_attr),
    .rd_req  (rd_req),
    .rd_addr (rd_addr)
  );

  vga_pixout u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (px_tick),
    .attr_i  (px_attr),
    .px_word (rd_data),
    .gain    (intensity),
    .hpol    (hsync_pol),
    .vpol    (vsync_pol),
    .dac_r   (dac_r),
    .dac_g   (dac_g),
    .dac_b   (dac_b),
    .hsync   (hsync),
    .vsync   (vsync)
  );

endmodule

// File: tb/vga_frac_streamer_test.sv
module vga_frac_streamer_test;
  localparam int HFP = 2, HSW = 3, HBP = 2, HACT = 4;
  localparam int VTOP = 2, VACT = 3, VBOT = 2, VSW = 2;
  localparam int HT = HFP + HSW + HBP + HACT;
  localparam int VT = VTOP + VACT + VBOT + VSW;
  localparam int HV0 = HFP + HSW + HBP;
  localparam int AW = $clog2(HACT * VACT * 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   freq_word = '0;
  logic [7:0]    intensity = '0;
  logic          hsync_pol = 1'b0, vsync_pol = 1'b0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic [15:0]   rd_data = '0;
  logic [7:0]    dac_r, dac_g, dac_b;
  logic          hsync, vsync;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vga_frac_streamer #(
    .HFP(HFP), .HSW(HSW), .HBP(HBP), .HACT(HACT),
    .VTOP(VTOP), .VACT(VACT), .VBOT(VBOT), .VSW(VSW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .intensity(intensity),
    .hsync_pol(hsync_pol), .vsync_pol(vsync_pol), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .dac_r(dac_r), .dac_g(dac_g),
    .dac_b(dac_b), .hsync(hsync), .vsync(vsync)
  );

  function automatic logic [15:0] memfn(int i);
    return 16'((i * 40503 + 12345) % 65536);
  endfunction

  always @(posedge clk) if (rd_req) rd_data <= memfn(int'(rd_addr) / 2);

  function automatic longint steps(longint e, longint f2);
    if (e <= 0) return 0;
    return (e * f2) / 64'h1_0000_0000;
  endfunction

  function automatic int gain_of(int c, int k);
    int kk = (k > 128) ? 128 : k;
    return (c * kk) / 128;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(logic [31:0] f, int k, bit hp, bit vp, int ncyc);
    longint f2, kp, kn, kq;
    int reqs = 0, exp_reqs = 0;
    freq_word = f; intensity = 8'(k); hsync_pol = hp; vsync_pol = vp;
    f2 = 2 * ((f > 32'h8000_0000) ? 64'h8000_0000 : longint'(f));
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dac_r == 0 && dac_g == 0 && dac_b == 0, "R9", "reset dac", dac_r, 0);
    chk(hsync == !hp && vsync == !vp, "R9 R3", "reset syncs", {hsync, vsync}, {!hp, !vp});
    chk(rd_req == 0, "R9", "reset rd_req", rd_req, 0);
    rst_n = 1'b1;
    for (int n = 1; n <= ncyc; n++) begin
      int ehs, evs, er, eg, eb;
      @(negedge clk);
      kq = steps(n - 2, f2);
      ehs = !hp; evs = !vp; er = 0; eg = 0; eb = 0;
      if (kq > 0) begin
        int p = int'(kq - 1);
        int h = p % HT, v = (p / HT) % VT;
        bit vis = (h >= HV0) && (v >= VTOP) && (v < VTOP + VACT);
        if (h >= HFP && h < HFP + HSW) ehs = hp;
        if (v >= VT - VSW) evs = vp;
        if (vis) begin
          logic [15:0] w = memfn((v - VTOP) * HACT + h - HV0);
          int rr = w[15:11], gg = w[10:5], bb = w[4:0];
          er = gain_of(rr * 8 + rr / 4, k);
          eg = gain_of(gg * 4 + gg / 16, k);
          eb = gain_of(bb * 8 + bb / 4, k);
        end
      end
      chk(hsync == ehs[0], "R2 R3 R9", "hsync", hsync, ehs);
      chk(vsync == evs[0], "R4 R3", "vsync", vsync, evs);
      if (er == 0 && eg == 0 && eb == 0)
        chk(dac_r == 0 && dac_g == 0 && dac_b == 0, "R6 R8", "black", {dac_r, dac_g, dac_b}, 0);
      else
        chk(dac_r == er && dac_g == eg && dac_b == eb, "R7 R8", "rgb",
            {dac_r, dac_g, dac_b}, {er[7:0], eg[7:0], eb[7:0]});
      kn = steps(n, f2); kp = steps(n - 1, f2);
      begin
        bit erq = 0;
        int ea = 0;
        if (kn > kp) begin
          int p = int'(kn - 1);
          int h = p % HT, v = (p / HT) % VT;
          if ((h >= HV0) && (v >= VTOP) && (v < VTOP + VACT)) begin
            erq = 1; ea = 2 * ((v - VTOP) * HACT + h - HV0);
          end
        end
        chk(rd_req == erq, "R5", "rd_req", rd_req, erq);
        if (erq) chk(int'(rd_addr) == ea, "R5", "rd_addr", rd_addr, ea);
      end
      if (rd_req) reqs++;
    end
    for (longint p = 0; p < steps(ncyc, f2); p++) begin
      int h = int'(p % HT), v = int'((p / HT) % VT);
      if ((h >= HV0) && (v >= VTOP) && (v < VTOP + VACT)) exp_reqs++;
    end
    chk(reqs == exp_reqs, "R1", "fetch count", reqs, exp_reqs);
  endtask

  initial begin
    run_case(32'h8000_0000, 128, 0, 0, 250);   // full rate, unity
    run_case(32'd671088640, 64, 0, 0, 800);    // 25/80 ratio, half gain
    run_case(32'hFFFF_FFFF, 200, 1, 1, 250);   // clamped rate and gain, active-high
    run_case(32'h0000_0000, 128, 0, 1, 100);   // frozen raster
    run_case(32'h2AAA_AAAB, 37, 1, 0, 700);    // one-third, two field wraps
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule